// File: doc/BRIEF.md
# Multi-Bank OUT Endpoint Receive Buffer

This block holds the received data of one device-side OUT endpoint. The endpoint storage is divided into one to three equal banks. The bus side writes packet bytes into the bank assigned to it with a byte strobe and closes that bank with an end-of-packet pulse. The banks are filled in round-robin order. The CPU side owns one bank at a time. It sees a received-data flag, an ownership flag and a read-allowed bit, and it reads the bank byte by byte. It acknowledges the notification with a write-one-to-clear pulse and returns the bank with a release pulse.

The CPU side is a three-state machine. CPU_WAIT means the CPU's bank is not yet full. CPU_NOTIFY means the bank is full and both flags are set. CPU_OWN means the notification is acknowledged and the bank is still held. The transitions are as follows. T_FULL takes CPU_WAIT to CPU_NOTIFY when the watched bank is full. T_ACK takes CPU_NOTIFY to CPU_OWN on an acknowledge. T_NEXT takes CPU_OWN to CPU_NOTIFY on a release when the following bank is already full. T_EMPTY takes CPU_OWN to CPU_WAIT on a release otherwise. A release seen in CPU_NOTIFY is rejected. Dropping the enable returns every state to CPU_WAIT. The bus side keeps a full bit and a byte count for each bank.

Top module: `out_ep_bank_ctrl`

## Requirements
- R1: While cfg_en is low, bus_ready is low and bus writes and end-of-packet pulses are ignored. No flag, full bank or overflow results from them, and dropping cfg_en returns the whole block to its reset state.
- R2: When the CPU's bank becomes full, rx_flag and own_flag rise in the same cycle, one clock after the end-of-packet is taken.
- R3: irq is high exactly while rx_flag is high and irq_en is 1.
- R4: A cpu_ack pulse clears rx_flag. own_flag, the read position and the bank data are unchanged, so the next byte read is still the first byte of the packet.
- R5: A cpu_release pulse while rx_flag is set is ignored. Both flags stay set and the bank stays owned.
- R6: A cpu_release pulse in the owned state frees the bank and advances to the next bank. If that bank is already full, rx_flag and own_flag are set again in the cycle right after the release. Otherwise both are low.
- R7: read_ok is high while the owned bank holds unread bytes. cpu_rdata shows the byte at the read position, and a cpu_rd pulse advances it, so bytes come out in arrival order.
- R8: cfg_banks selects 1, 2 or 3 banks, with 0 treated as 1. Packets are delivered to the CPU in the order they arrived, and bus_ready is high exactly while fewer banks than configured hold unconsumed packets.
- R9: A bus_wr or bus_eop pulse while bus_ready is low is dropped and sets overflow. overflow stays set until cfg_en goes low.
- R10: A zero-length packet fills a bank and sets both flags, while read_ok stays low.
- R11: While read_ok is low, cpu_rdata is 0 and a cpu_rd pulse does not move the read position.
- R12: Bytes beyond BANK_BYTES in one packet are discarded and set overflow. The bank keeps its first BANK_BYTES bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Endpoint enabled; low clears all state |
| cfg_banks | input | 2 | Number of banks (0 or 1 = one bank) |
| irq_en | input | 1 | Received-data interrupt enable |
| bus_wr | input | 1 | Bus byte strobe |
| bus_data | input | 8 | Bus byte |
| bus_eop | input | 1 | End of packet; closes the bus bank |
| bus_ready | output | 1 | Bus bank available |
| overflow | output | 1 | Sticky dropped-data flag |
| cpu_rd | input | 1 | Pop one byte |
| cpu_rdata | output | 8 | Byte at the read position, 0 when none |
| cpu_ack | input | 1 | Write-one-to-clear of rx_flag |
| cpu_release | input | 1 | Release the owned bank |
| rx_flag | output | 1 | Received data waiting |
| own_flag | output | 1 | CPU owns a full bank |
| read_ok | output | 1 | Unread bytes in owned bank |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills banks with packets of random length, zero-length packets included, interleaved with consumption. A design that delivered banks out of order, or that lost the length of a zero-length bank, shows up as a byte mismatch or a wrong read_ok. A release is sent while the notification is still pending, to catch a design that frees the bank too early. A release is also sent when the next bank is already full, to catch a machine that stalls in CPU_WAIT for a cycle. The tests also cover an oversize packet, writes into a fully occupied endpoint, reads past the end of a bank and a bank count of zero. These cases expose a design that writes past the bank or lets a blocked write into storage. They also expose an overflow flag that is not sticky and a pointer that moves on an empty read.

// File: rtl/ep_out_pkg.sv
package ep_out_pkg;
    typedef enum logic [1:0] {
        CPU_WAIT   = 2'd0,
        CPU_NOTIFY = 2'd1,
        CPU_OWN    = 2'd2
    } cpu_state_t;
endpackage

// File: rtl/ep_bank_mem.sv
module ep_bank_mem #(
    parameter int NB = 3,
    parameter int BB = 8,
    parameter int BW = 2,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [BW-1:0] wbank,
    input  logic [AW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [BW-1:0] rbank,
    input  logic [AW-1:0] ridx,
    output logic [7:0]    rdata
);
    localparam int DEPTH = NB * BB;
    localparam int DW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    store [DEPTH];
    logic [DW-1:0] waddr;
    logic [DW-1:0] raddr;

    always_comb begin
        waddr = DW'(wbank) * DW'(BB) + DW'(widx);
        raddr = DW'(rbank) * DW'(BB) + DW'(ridx);
    end

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/ep_fill_ctl.sv
module ep_fill_ctl #(
    parameter int NB = 3,
    parameter int BB = 8,
    parameter int BW = 2,
    parameter int AW = 3,
    parameter int PW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [BW-1:0]        last_bank,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_data,
    input  logic                 bus_eop,
    input  logic                 rel,
    input  logic [BW-1:0]        rel_bank,
    output logic                 bus_ready,
    output logic                 overflow,
    output logic [NB-1:0]        full,
    output logic [NB-1:0][PW-1:0] cnt,
    output logic                 mem_we,
    output logic [BW-1:0]        mem_bank,
    output logic [AW-1:0]        mem_idx,
    output logic [7:0]           mem_data
);
    logic [BW-1:0] wbank;
    logic [PW-1:0] wcnt;
    logic          room;

    function automatic logic [BW-1:0] step(input logic [BW-1:0] b, input logic [BW-1:0] last);
        return (b >= last) ? '0 : b + 1'b1;
    endfunction

    always_comb begin
        bus_ready = en && !full[wbank];
        room      = wcnt < PW'(BB);
        mem_we    = bus_ready && bus_wr && room;
        mem_bank  = wbank;
        mem_idx   = wcnt[AW-1:0];
        mem_data  = bus_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            full     <= '0;
            cnt      <= '0;
            wbank    <= '0;
            wcnt     <= '0;
            overflow <= 1'b0;
        end else begin
            if (rel) full[rel_bank] <= 1'b0;
            if ((bus_wr || bus_eop) && !bus_ready) overflow <= 1'b1;
            if (bus_wr && bus_ready && !room) overflow <= 1'b1;
            if (mem_we) wcnt <= wcnt + 1'b1;
            if (bus_eop && bus_ready) begin
                full[wbank] <= 1'b1;
                cnt[wbank]  <= wcnt + PW'(mem_we);
                wcnt        <= '0;
                wbank       <= step(wbank, last_bank);
            end
        end
    end

    a_r9_blocked_sets_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (bus_wr || bus_eop) && !bus_ready) |=> overflow);

    a_r1_disabled_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (!overflow && full == '0));

    a_r12_clip_sets_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bus_wr && bus_ready && !room) |=> overflow);
endmodule

// File: rtl/ep_cpu_fsm.sv
module ep_cpu_fsm
    import ep_out_pkg::*;
#(
    parameter int NB = 3,
    parameter int BW = 2,
    parameter int AW = 3,
    parameter int PW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [BW-1:0]         last_bank,
    input  logic [NB-1:0]         full,
    input  logic [NB-1:0][PW-1:0] cnt,
    input  logic                  cpu_rd,
    input  logic                  cpu_ack,
    input  logic                  cpu_release,
    input  logic                  irq_en,
    output logic                  rx_flag,
    output logic                  own_flag,
    output logic                  read_ok,
    output logic                  irq,
    output logic [BW-1:0]         rd_bank,
    output logic [AW-1:0]         rd_idx,
    output logic                  rel,
    output logic [BW-1:0]         rel_bank
);
    cpu_state_t    state, nstate;
    logic [BW-1:0] rbank, nbk;
    logic [PW-1:0] ptr;

    always_comb begin
        nbk    = (rbank >= last_bank) ? '0 : rbank + 1'b1;
        nstate = state;
        unique case (state)
            CPU_WAIT:   if (full[rbank]) nstate = CPU_NOTIFY;
            CPU_NOTIFY: if (cpu_ack) nstate = CPU_OWN;
            CPU_OWN:    if (cpu_release)
                            nstate = ((nbk != rbank) && full[nbk]) ? CPU_NOTIFY : CPU_WAIT;
            default:    nstate = CPU_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state <= CPU_WAIT;
            rbank <= '0;
            ptr   <= '0;
        end else begin
            state <= nstate;
            if (rel) rbank <= nbk;
            if (state != CPU_NOTIFY && nstate == CPU_NOTIFY) ptr <= '0;
            else if (cpu_rd && read_ok) ptr <= ptr + 1'b1;
        end
    end

    always_comb begin
        rx_flag  = (state == CPU_NOTIFY);
        own_flag = (state != CPU_WAIT);
        read_ok  = own_flag && (ptr < cnt[rbank]);
        irq      = rx_flag && irq_en;
        rel      = (state == CPU_OWN) && cpu_release;
        rel_bank = rbank;
        rd_bank  = rbank;
        rd_idx   = ptr[AW-1:0];
    end

    a_r5_release_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_flag && cpu_release && !cpu_ack) |=> (rx_flag && own_flag && $stable(rbank)));

    a_r4_ack_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_flag && cpu_ack && !cpu_rd) |=> (!rx_flag && own_flag && $stable(ptr)));

    a_r11_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && own_flag && cpu_rd && !read_ok && !cpu_release) |=> $stable(ptr));

    a_r6_release_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rel && last_bank != '0) |=> (rbank != $past(rbank)));

    a_r2_flags_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $rose(own_flag) || $past(state) == CPU_OWN);
endmodule

// File: rtl/out_ep_bank_ctrl.sv
module out_ep_bank_ctrl #(
    parameter int NBANK      = 3,
    parameter int BANK_BYTES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_en,
    input  logic [1:0] cfg_banks,
    input  logic       irq_en,
    input  logic       bus_wr,
    input  logic [7:0] bus_data,
    input  logic       bus_eop,
    output logic       bus_ready,
    output logic       overflow,
    input  logic       cpu_rd,
    output logic [7:0] cpu_rdata,
    input  logic       cpu_ack,
    input  logic       cpu_release,
    output logic       rx_flag,
    output logic       own_flag,
    output logic       read_ok,
    output logic       irq
);
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int AW = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1;
    localparam int PW = $clog2(BANK_BYTES + 1);

    logic [BW-1:0]            last_bank;
    logic [NBANK-1:0]         full;
    logic [NBANK-1:0][PW-1:0] cnt;
    logic                     mem_we, rel;
    logic [BW-1:0]            mem_bank, rd_bank, rel_bank;
    logic [AW-1:0]            mem_idx, rd_idx;
    logic [7:0]               mem_data, mem_rdata;

    always_comb begin
        if (cfg_banks == 2'd0)                 last_bank = '0;
        else if (32'(cfg_banks) > NBANK)       last_bank = BW'(NBANK - 1);
        else                                   last_bank = BW'(cfg_banks - 2'd1);
    end

    ep_fill_ctl #(.NB(NBANK), .BB(BANK_BYTES), .BW(BW), .AW(AW), .PW(PW)) u_fill (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .last_bank(last_bank),
        .bus_wr(bus_wr), .bus_data(bus_data), .bus_eop(bus_eop),
        .rel(rel), .rel_bank(rel_bank),
        .bus_ready(bus_ready), .overflow(overflow), .full(full), .cnt(cnt),
        .mem_we(mem_we), .mem_bank(mem_bank), .mem_idx(mem_idx), .mem_data(mem_data)
    );

    ep_bank_mem #(.NB(NBANK), .BB(BANK_BYTES), .BW(BW), .AW(AW)) u_mem (
        .clk(clk), .we(mem_we), .wbank(mem_bank), .widx(mem_idx), .wdata(mem_data),
        .rbank(rd_bank), .ridx(rd_idx), .rdata(mem_rdata)
    );

    ep_cpu_fsm #(.NB(NBANK), .BW(BW), .AW(AW), .PW(PW)) u_cpu (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .last_bank(last_bank),
        .full(full), .cnt(cnt), .cpu_rd(cpu_rd), .cpu_ack(cpu_ack),
        .cpu_release(cpu_release), .irq_en(irq_en),
        .rx_flag(rx_flag), .own_flag(own_flag), .read_ok(read_ok), .irq(irq),
        .rd_bank(rd_bank), .rd_idx(rd_idx), .rel(rel), .rel_bank(rel_bank)
    );

    assign cpu_rdata = read_ok ? mem_rdata : 8'h00;

    a_r7_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_flag) |-> (!read_ok && cpu_rdata == 8'h00));
endmodule

// File: tb/sim_out_ep_bank_ctrl.sv
`timescale 1ns/1ps
module sim_out_ep_bank_ctrl;
    localparam int NB = 3;
    localparam int BB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, cfg_en = 1'b0, irq_en = 1'b0;
    logic [1:0] cfg_banks = 2'd1;
    logic bus_wr = 1'b0, bus_eop = 1'b0, cpu_rd = 1'b0, cpu_ack = 1'b0, cpu_release = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic bus_ready, overflow, rx_flag, own_flag, read_ok, irq;
    logic [7:0] cpu_rdata;

    always #2 clk = ~clk;

    out_ep_bank_ctrl #(.NBANK(NB), .BANK_BYTES(BB)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_banks(cfg_banks), .irq_en(irq_en),
        .bus_wr(bus_wr), .bus_data(bus_data), .bus_eop(bus_eop), .bus_ready(bus_ready),
        .overflow(overflow), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .cpu_release(cpu_release), .rx_flag(rx_flag), .own_flag(own_flag),
        .read_ok(read_ok), .irq(irq)
    );

    int errs = 0, checks = 0;
    bit done = 0;
    logic [7:0] pk_data [16][BB];
    int pk_len [16];
    int head = 0, tail = 0, pending = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int clipped(input int n);
        return (n > BB) ? BB : n;
    endfunction

    task automatic send_pkt(input int n, input bit keep);
        for (int i = 0; i < n; i++) begin
            bus_wr = 1'b1;
            bus_data = 8'($urandom);
            if (keep && i < BB) pk_data[tail][i] = bus_data;
            tick();
            bus_wr = 1'b0;
        end
        bus_eop = 1'b1;
        tick();
        bus_eop = 1'b0;
        if (keep) begin
            pk_len[tail] = clipped(n);
            tail = (tail + 1) % 16;
            pending++;
        end
    endtask

    task automatic wait_own(input string tag);
        int k = 0;
        while (!own_flag && k < 20) begin
            tick();
            k++;
        end
        chk({tag, " own_flag set"}, int'(own_flag), 1);
        chk({tag, " rx_flag with own"}, int'(rx_flag), 1);
    endtask

    task automatic finish_bank(input string tag);
        int len;
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        chk("R4 ack clears rx", int'(rx_flag), 0);
        chk("R4 ack keeps own", int'(own_flag), 1);
        len = pk_len[head];
        if (len == 0) chk("R10 zlp read_ok low", int'(read_ok), 0);
        for (int i = 0; i < len; i++) begin
            chk({tag, " R7 read_ok"}, int'(read_ok), 1);
            chk({tag, " R7 byte"}, int'(cpu_rdata), int'(pk_data[head][i]));
            cpu_rd = 1'b1;
            tick();
            cpu_rd = 1'b0;
        end
        chk("R7 read_ok low at end", int'(read_ok), 0);
        chk("R11 empty rdata", int'(cpu_rdata), 0);
        cpu_rd = 1'b1;
        tick();
        cpu_rd = 1'b0;
        chk("R11 rdata after empty read", int'(cpu_rdata), 0);
        head = (head + 1) % 16;
        pending--;
        cpu_release = 1'b1;
        tick();
        cpu_release = 1'b0;
        chk("R6 flags after release", int'(rx_flag), (pending > 0) ? 1 : 0);
        chk("R6 own after release", int'(own_flag), (pending > 0) ? 1 : 0);
    endtask

    task automatic consume(input string tag);
        wait_own({tag, " R2"});
        finish_bank(tag);
    endtask

    task automatic reconfig(input logic [1:0] nb);
        cfg_en = 1'b0;
        tick();
        cfg_banks = nb;
        cfg_en = 1'b1;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset ready", int'(bus_ready), 0);
        chk("R1 reset rx", int'(rx_flag), 0);
        chk("R1 reset own", int'(own_flag), 0);
        chk("R1 reset overflow", int'(overflow), 0);
        chk("R1 reset irq", int'(irq), 0);

        send_pkt(3, 0);
        tick(); tick();
        chk("R1 unconfigured own", int'(own_flag), 0);
        chk("R1 unconfigured overflow", int'(overflow), 0);

        cfg_banks = 2'd1; cfg_en = 1'b1; irq_en = 1'b1;
        tick();
        chk("R1 configured ready", int'(bus_ready), 1);

        send_pkt(5, 1);
        wait_own("R2 single");
        chk("R3 irq enabled", int'(irq), 1);
        irq_en = 1'b0;
        #1;
        chk("R3 irq masked", int'(irq), 0);
        irq_en = 1'b1;
        chk("R9 single bank owned ready", int'(bus_ready), 0);
        cpu_release = 1'b1;
        tick();
        cpu_release = 1'b0;
        chk("R5 rx kept", int'(rx_flag), 1);
        chk("R5 own kept", int'(own_flag), 1);
        finish_bank("R7 single");
        chk("R8 ready after release", int'(bus_ready), 1);

        for (int nb = 2; nb <= 3; nb++) begin
            reconfig(2'(nb));
            send_pkt(0, 1);
            for (int r = 0; r < 12; r++) begin
                while (pending < nb && (pending == 0 || ($urandom % 4) != 0))
                    send_pkt(int'($urandom % (BB + 1)), 1);
                chk("R8 ready vs occupancy", int'(bus_ready), (pending < nb) ? 1 : 0);
                consume("R8 rand");
            end
            while (pending > 0) consume("R8 drain");
        end

        reconfig(2'd2);
        send_pkt(BB + 2, 1);
        chk("R12 oversize overflow", int'(overflow), 1);
        consume("R12 clipped");

        reconfig(2'd1);
        chk("R9 overflow cleared by disable", int'(overflow), 0);
        send_pkt(2, 1);
        chk("R9 ready low when full", int'(bus_ready), 0);
        chk("R9 no overflow yet", int'(overflow), 0);
        bus_wr = 1'b1; bus_data = 8'hA5;
        tick();
        bus_wr = 1'b0;
        chk("R9 blocked write overflow", int'(overflow), 1);
        consume("R9 dropped byte absent");
        chk("R9 overflow sticky", int'(overflow), 1);

        reconfig(2'd0);
        send_pkt(1, 1);
        chk("R8 zero banks acts as one", int'(bus_ready), 0);
        consume("R8 zero banks");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule